// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Unit

This block computes the sine and cosine of a signed fixed-point angle anywhere on the circle from minus pi to plus pi. One angle can enter on every clock together with a valid strobe. Both results leave the block a fixed 12 cycles later, with an output strobe that marks the cycles whose data are good. A continuous sweep of angles therefore streams through the block without stalls.

The datapath first folds the angle into the half circle around zero. Any angle beyond plus or minus pi/2 has pi removed or added, and a flag is kept that negates both results at the end. The folded angle then drives eleven rotation-mode CORDIC iterations, one register stage each. Each iteration uses only shifts, additions and a constant arctangent. The start vector already carries the inverse CORDIC gain, so no multiplier is needed. A final registered stage rounds the results to the output width and applies the fold sign. The valid strobe travels through a separate shift line of the same depth, which is the only state the reset clears.

Top module: `cordic_sincos`

## Requirements
- R1: `vld_o` equals `vld_i` delayed by exactly 12 clock cycles: an angle presented in cycle c appears on the outputs in cycle c+12.
- R2: While `rst_ni` is low, and for the first 12 cycles after it rises, `vld_o` is 0. Reset may be applied in the middle of a stream, and it discards every sample in flight.
- R3: For every valid angle code in -102944..102944, `sin_o` and `cos_o` each differ from the ideal value by at most 1.1e-3, which is 72 output LSBs.
- R4: `ang_i` is two's complement with 15 fractional bits (code 32768 = 1 rad). `sin_o` and `cos_o` are two's complement with 16 fractional bits (code 65536 = 1.0). Angle code 0 gives `cos_o` within 72 of 65536 and `sin_o` within 72 of 0.
- R5: Valid angles on consecutive cycles give valid results on consecutive cycles, in the same order, with no gaps.
- R6: A valid angle whose magnitude exceeds pi/2 + 0.01 rad (code 51800) gives a negative `cos_o`. A valid angle whose magnitude is below pi/2 - 0.01 rad (code 51144) gives a positive `cos_o`. The codes ±102944 give `cos_o` within 72 of -65536.
- R7: An angle presented with `vld_i` low has no effect on any valid result, and 12 cycles later `vld_o` is low.
- R8: For every valid result, sin_o² + cos_o² lies within 0.5 % of 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the valid line |
| vld_i | input | 1 | Angle valid strobe |
| ang_i | input | 18 | Angle, signed, 15 fractional bits |
| vld_o | output | 1 | Result valid strobe, 12 cycles after `vld_i` |
| sin_o | output | 18 | Sine, signed, 16 fractional bits |
| cos_o | output | 18 | Cosine, signed, 16 fractional bits |

## Verification
A fold flag that is wrong or carried in the wrong slot shows as both results with the wrong sign, for angles beyond ±pi/2 only. That error appears exactly 12 cycles after the angle entered, and the per-sample error and cosine sign checks catch it. A bad arctangent constant or a wrong shift in any one iteration shows as an error above 72 LSBs across most of the sweep, often with a vector magnitude that is off as well. A valid line of the wrong depth, or one that reset does not clear, shows on the first sample as a strobe one or more cycles early or late, or as a strobe that appears out of reset. The cycle-accurate reference flags it on that first cycle.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  // arctan(2^-i) rounded to frac fractional bits
  function automatic int atan_q(int i, int frac);
    return $rtoi($atan(2.0 ** (-i)) * (2.0 ** frac) + 0.5);
  endfunction

  // 1/K for n iterations, rounded to frac fractional bits
  function automatic int inv_gain_q(int n, int frac);
    real k;
    k = 1.0;
    for (int i = 0; i < n; i++) k = k * $sqrt(1.0 + 2.0 ** (-2 * i));
    return $rtoi((2.0 ** frac) / k + 0.5);
  endfunction

  function automatic int pi_q(int frac);
    return $rtoi(3.14159265358979 * (2.0 ** frac) + 0.5);
  endfunction

endpackage

// File: rtl/sincos_fold.sv
module sincos_fold #(
  parameter int DATA_W = 18,
  parameter int GUARD  = 4,
  parameter int Z_W    = DATA_W + GUARD,
  parameter logic signed [Z_W-1:0] PI_Z  = '0,
  parameter logic signed [Z_W-1:0] HPI_Z = '0
) (
  input  logic signed [DATA_W-1:0] ang_i,
  output logic signed [Z_W-1:0]    z_o,
  output logic                     neg_o
);

  logic signed [Z_W-1:0] z_in;
  assign z_in = {ang_i, {GUARD{1'b0}}};

  always_comb begin
    if (z_in > HPI_Z) begin
      z_o   = z_in - PI_Z;
      neg_o = 1'b1;
    end else if (z_in < -HPI_Z) begin
      z_o   = z_in + PI_Z;
      neg_o = 1'b1;
    end else begin
      z_o   = z_in;
      neg_o = 1'b0;
    end
  end

endmodule

// File: rtl/sincos_stage.sv
module sincos_stage #(
  parameter int XY_W  = 22,
  parameter int Z_W   = 22,
  parameter int SHIFT = 0,
  parameter logic signed [Z_W-1:0] ATAN = '0
) (
  input  logic                   clk_i,
  input  logic signed [XY_W-1:0] x_i,
  input  logic signed [XY_W-1:0] y_i,
  input  logic signed [Z_W-1:0]  z_i,
  input  logic                   neg_i,
  output logic signed [XY_W-1:0] x_o,
  output logic signed [XY_W-1:0] y_o,
  output logic signed [Z_W-1:0]  z_o,
  output logic                   neg_o
);

  logic signed [XY_W-1:0] x_sh, y_sh;
  assign x_sh = x_i >>> SHIFT;
  assign y_sh = y_i >>> SHIFT;

  // data path carries no reset: only the valid line must be exact
  always_ff @(posedge clk_i) begin
    if (z_i[Z_W-1]) begin
      x_o <= x_i + y_sh;
      y_o <= y_i - x_sh;
      z_o <= z_i + ATAN;
    end else begin
      x_o <= x_i - y_sh;
      y_o <= y_i + x_sh;
      z_o <= z_i - ATAN;
    end
    neg_o <= neg_i;
  end

endmodule

// File: rtl/sincos_fix.sv
module sincos_fix #(
  parameter int DATA_W = 18,
  parameter int GUARD  = 4,
  parameter int XY_W   = DATA_W + GUARD
) (
  input  logic                     clk_i,
  input  logic signed [XY_W-1:0]   x_i,
  input  logic signed [XY_W-1:0]   y_i,
  input  logic                     neg_i,
  output logic signed [DATA_W-1:0] cos_o,
  output logic signed [DATA_W-1:0] sin_o
);

  localparam logic signed [XY_W-1:0] RND = XY_W'(1 << (GUARD - 1));

  logic signed [XY_W-1:0]   x_rnd, y_rnd;
  logic signed [DATA_W-1:0] x_cut, y_cut;
  logic                     unused_lsb;

  assign x_rnd = x_i + RND;
  assign y_rnd = y_i + RND;
  assign x_cut = x_rnd[GUARD +: DATA_W];
  assign y_cut = y_rnd[GUARD +: DATA_W];
  assign unused_lsb = ^{x_rnd[GUARD-1:0], y_rnd[GUARD-1:0]};

  always_ff @(posedge clk_i) begin
    cos_o <= neg_i ? -x_cut : x_cut;
    sin_o <= neg_i ? -y_cut : y_cut;
  end

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
  parameter int DATA_W   = 18,
  parameter int ANG_FRAC = 15,
  parameter int OUT_FRAC = 16,
  parameter int ITER     = 11,
  parameter int GUARD    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] ang_i,
  output logic                     vld_o,
  output logic signed [DATA_W-1:0] sin_o,
  output logic signed [DATA_W-1:0] cos_o
);

  localparam int XY_W    = DATA_W + GUARD;
  localparam int Z_W     = DATA_W + GUARD;
  localparam int Z_FRAC  = ANG_FRAC + GUARD;
  localparam int XY_FRAC = OUT_FRAC + GUARD;
  localparam int LAT     = ITER + 1;

  localparam logic signed [Z_W-1:0]  PI_Z  = Z_W'(sincos_pkg::pi_q(Z_FRAC));
  localparam logic signed [Z_W-1:0]  HPI_Z = PI_Z >>> 1;
  localparam logic signed [XY_W-1:0] INV_K = XY_W'(sincos_pkg::inv_gain_q(ITER, XY_FRAC));

  logic signed [XY_W-1:0] x_q [ITER+1];
  logic signed [XY_W-1:0] y_q [ITER+1];
  logic signed [Z_W-1:0]  z_q [ITER+1];
  logic                   n_q [ITER+1];

  sincos_fold #(
    .DATA_W(DATA_W), .GUARD(GUARD), .Z_W(Z_W), .PI_Z(PI_Z), .HPI_Z(HPI_Z)
  ) u_fold (
    .ang_i(ang_i), .z_o(z_q[0]), .neg_o(n_q[0])
  );

  // gain compensation sits in the start vector
  assign x_q[0] = INV_K;
  assign y_q[0] = '0;

  for (genvar g = 0; g < ITER; g++) begin : g_iter
    localparam logic signed [Z_W-1:0] ATAN_G = Z_W'(sincos_pkg::atan_q(g, Z_FRAC));
    sincos_stage #(
      .XY_W(XY_W), .Z_W(Z_W), .SHIFT(g), .ATAN(ATAN_G)
    ) u_stage (
      .clk_i(clk_i),
      .x_i(x_q[g]),   .y_i(y_q[g]),   .z_i(z_q[g]),   .neg_i(n_q[g]),
      .x_o(x_q[g+1]), .y_o(y_q[g+1]), .z_o(z_q[g+1]), .neg_o(n_q[g+1])
    );
  end

  logic unused_z;
  assign unused_z = ^z_q[ITER];

  sincos_fix #(
    .DATA_W(DATA_W), .GUARD(GUARD), .XY_W(XY_W)
  ) u_fix (
    .clk_i(clk_i),
    .x_i(x_q[ITER]), .y_i(y_q[ITER]), .neg_i(n_q[ITER]),
    .cos_o(cos_o), .sin_o(sin_o)
  );

  logic [LAT-1:0] vld_sr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_sr <= '0;
    else         vld_sr <= {vld_sr[LAT-2:0], vld_i};
  end
  assign vld_o = vld_sr[LAT-1];

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
  parameter int LAT      = 12,
  parameter int DATA_W   = 18,
  parameter int OUT_FRAC = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     vld_i,
  input logic                     vld_o,
  input logic signed [DATA_W-1:0] sin_o,
  input logic signed [DATA_W-1:0] cos_o
);

  localparam longint ONE  = longint'(1) << (2 * OUT_FRAC);
  localparam longint NTOL = ONE / 200;
  localparam int     MAXV = (1 << OUT_FRAC) + 128;

  int since_rst;
  int in_flight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= 0;
      in_flight <= 0;
    end else begin
      if (since_rst < LAT) since_rst <= since_rst + 1;
      in_flight <= in_flight + int'(vld_i) - int'(vld_o);
    end
  end

  longint norm;
  assign norm = longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o);

  // R2
  quiet_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < LAT) |-> !vld_o);

  // R1
  valid_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (in_flight > 0));

  // R5
  in_flight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_flight <= LAT);

  // R3
  output_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (int'(sin_o) <= MAXV && int'(sin_o) >= -MAXV &&
               int'(cos_o) <= MAXV && int'(cos_o) >= -MAXV));

  // R8
  unit_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (norm <= ONE + NTOL && norm >= ONE - NTOL));

endmodule

bind cordic_sincos cordic_sincos_chk #(
  .LAT(LAT), .DATA_W(DATA_W), .OUT_FRAC(OUT_FRAC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i),
  .vld_o(vld_o), .sin_o(sin_o), .cos_o(cos_o)
);

// File: tb/cordic_sincos_tb.sv
module cordic_sincos_tb;

  localparam int CLK_P  = 10;
  localparam int LAT    = 12;
  localparam int PI_C   = 102944;
  localparam int HPI_C  = 51472;
  localparam real TOL   = 72.0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vld_i = 1'b0;
  logic signed [17:0] ang_i = '0;
  logic vld_o;
  logic signed [17:0] sin_o, cos_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit    vq[$];
  int    aq[$];
  string tq[$];

  always #(CLK_P / 2) clk = ~clk;

  cordic_sincos u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .ang_i(ang_i),
    .vld_o(vld_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  task automatic bad(string req, string what, real act, real exp);
    errors++;
    $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
  endtask

  task automatic near(string req, string what, real act, real exp);
    checks++;
    if (act - exp > TOL || exp - act > TOL) bad(req, what, act, exp);
  endtask

  task automatic check_out();
    bit ev;
    int ea;
    string tg;
    real th;
    if (vq.size() == LAT) begin
      ev = vq.pop_front(); ea = aq.pop_front(); tg = tq.pop_front();
    end else begin
      ev = 1'b0; ea = 0; tg = "R2";
    end
    checks++;
    if (vld_o !== ev) bad(tg, "vld_o", real'(vld_o), real'(ev));
    if (ev && vld_o === 1'b1) begin
      th = real'(ea) / 32768.0;
      near("R3", "sin_o", real'(sin_o), $sin(th) * 65536.0);
      near("R3", "cos_o", real'(cos_o), $cos(th) * 65536.0);
      if (ea == 0) begin
        near("R4", "cos_o@0", real'(cos_o), 65536.0);
        near("R4", "sin_o@0", real'(sin_o), 0.0);
      end
      if (ea > HPI_C + 328 || ea < -HPI_C - 328) begin
        checks++;
        if (cos_o >= 0) bad("R6", "cos_o sign", real'(cos_o), -1.0);
      end
      if (ea < HPI_C - 328 && ea > -HPI_C + 328) begin
        checks++;
        if (cos_o <= 0) bad("R6", "cos_o sign", real'(cos_o), 1.0);
      end
      if (ea == PI_C || ea == -PI_C) near("R6", "cos_o@pi", real'(cos_o), -65536.0);
      begin
        real n;
        n = (real'(sin_o) * real'(sin_o) + real'(cos_o) * real'(cos_o)) / 4294967296.0;
        checks++;
        if (n > 1.005 || n < 0.995) bad("R8", "norm", n, 1.0);
      end
    end
  endtask

  task automatic step(bit v, int a, string tg);
    @(negedge clk);
    check_out();
    vld_i = v;
    ang_i = 18'(a);
    vq.push_back(v); aq.push_back(a); tq.push_back(tg);
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst_ni = 1'b0;
    vld_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (vld_o !== 1'b0) bad("R2", "vld_o in reset", real'(vld_o), 0.0);
    end
    vq.delete(); aq.delete(); tq.delete();
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int edges[14];
    edges = '{PI_C, -PI_C, HPI_C, HPI_C + 1, HPI_C - 1, -HPI_C, -HPI_C + 1,
              -HPI_C - 1, 1, -1, 0, 77000, -77000, 25000};

    // R2: reset clears valid line
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (vld_o !== 1'b0) bad("R2", "vld_o in reset", real'(vld_o), 0.0);
    end
    rst_ni = 1'b1;

    // R1/R4: single sample at zero, then idle
    step(1'b1, 0, "R1");
    for (int i = 0; i < 16; i++) step(1'b0, 0, "R1");

    // R6: fold boundaries back to back
    foreach (edges[k]) step(1'b1, edges[k], "R6");
    for (int i = 0; i < 13; i++) step(1'b0, 0, "R1");

    // R3/R5: continuous sweep over the full circle
    for (int a = -PI_C; a <= PI_C; a += 37) step(1'b1, a, "R5");
    step(1'b1, PI_C, "R5");

    // R7: random gaps, garbage angles on invalid cycles
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 2) != 0)
        step(1'b1, int'($urandom_range(0, 2 * PI_C)) - PI_C, "R7");
      else
        step(1'b0, int'($urandom_range(0, 262143)) - 131072, "R7");
    end

    // R2: reset in the middle of a stream
    do_reset(3);
    for (int i = 0; i < 200; i++) step(1'b1, (i * 1031) % (2 * PI_C) - PI_C, "R2");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 0, "R7");

    finish_run();
  end

endmodule